// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides, for one cache-block operation at a time, whether a hart may run it in its current privilege mode. The operation can be an invalidate, a clean, a flush, a zero or a prefetch. If the operation may not run, the block says whether it must raise an illegal-instruction exception or a virtual-instruction exception. The inputs are the privilege mode, the operation class and three 4-bit enable groups, one each from the machine, supervisor and hypervisor environment-configuration registers.

The decision is registered once. It is held as a verdict state, and the outputs are decoded from that state. The states are:
- `ST_IDLE`: no request.
- `ST_EXEC`: run the operation as requested.
- `ST_EXEC_FLUSH`: run an invalidate as a flush.
- `ST_ILLEGAL`: raise an illegal-instruction exception.
- `ST_VIRTUAL`: raise a virtual-instruction exception.

On every clock edge the next state is computed from the current inputs alone. A request with `valid_i` low moves to `ST_IDLE`. A permitted request moves to `ST_EXEC` or `ST_EXEC_FLUSH`. A request blocked by a machine-level or supervisor-level field, or a request with an unlisted code, moves to `ST_ILLEGAL`. A request blocked only in a virtualized mode moves to `ST_VIRTUAL`. Reset forces `ST_IDLE`.

Top module: `cbo_perm_checker`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, all four outputs are 0.
- R2: A request is reflected on the outputs one clock after it is sampled. A cycle with `valid_i` low yields all outputs 0 one clock later, whatever the other inputs are.
- R3: Bits [1:0] of each enable group gate the invalidate operation (op code 0). The value 00 traps, 01 permits the operation as a flush, 11 permits a true invalidate, and the reserved value 10 traps like 00.
- R4: Bit 2 of each enable group gates both clean (op 1) and flush (op 2). Bit 3 gates zero (op 3). In both bits, 0 traps and 1 permits.
- R5: The mode codes are U=000, S=001, M=011, VU=100 and VS=101. An illegal-instruction exception is raised in either of two cases: the mode is not M and the machine group blocks the operation, or the mode is U and the supervisor group blocks it. In M mode, every listed operation executes.
- R6: The virtual-instruction exception is considered only when no illegal-instruction exception applies. It is raised in VS when the hypervisor group blocks the operation. It is raised in VU when the hypervisor group or the supervisor group blocks it.
- R7: A prefetch (op 4) executes in every listed mode, whatever the enable groups hold.
- R8: One clock after a valid request, exactly one of `exec_o`, `illegal_o` and `virtual_o` is 1.
- R9: `as_flush_o` is 1 only together with `exec_o` for an invalidate. This happens when any group checked in that mode holds 01: machine in every mode except M, supervisor in U and VU, hypervisor in VS and VU.
- R10: A valid request with an unlisted mode code (010, 110, 111) or an unlisted op code (5 to 7) raises an illegal-instruction exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request present |
| mode_i | input | 3 | Privilege mode code |
| op_i | input | 3 | Operation class code |
| m_cfg_i | input | 4 | Machine enable group {zero, clean/flush, inval[1:0]} |
| s_cfg_i | input | 4 | Supervisor enable group, same layout |
| h_cfg_i | input | 4 | Hypervisor enable group, same layout |
| exec_o | output | 1 | Operation may execute |
| as_flush_o | output | 1 | Invalidate is to be performed as a flush |
| illegal_o | output | 1 | Raise illegal-instruction exception |
| virtual_o | output | 1 | Raise virtual-instruction exception |

## Verification
The hardest cases to reach are those where two enable groups disagree in a virtualized mode. One example is a VU invalidate whose machine group grants a full invalidate while the supervisor group grants only a flush and the hypervisor group traps. In that case the illegal/virtual ordering and the flush demotion interact. Another example is the reserved value 10 sitting in just one of the three groups. The bench reaches all of these by sweeping every 12-bit combination of the three groups for every listed mode and operation. It then adds unlisted mode and op codes, and requests with `valid_i` low.

// File: rtl/cbo_perm_pkg.sv
package cbo_perm_pkg;

    localparam int MODE_W = 3;
    localparam int OP_W   = 3;
    localparam int CFG_W  = 4;
    localparam int N_LVL  = 3;

    localparam int LVL_M = 0;
    localparam int LVL_S = 1;
    localparam int LVL_H = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_U  = 3'b000,
        MD_S  = 3'b001,
        MD_M  = 3'b011,
        MD_VU = 3'b100,
        MD_VS = 3'b101
    } mode_e;

    typedef enum logic [OP_W-1:0] {
        OPC_INVAL = 3'd0,
        OPC_CLEAN = 3'd1,
        OPC_FLUSH = 3'd2,
        OPC_ZERO  = 3'd3,
        OPC_PREF  = 3'd4
    } op_e;

    // Per-level grant for the requested operation
    typedef enum logic [1:0] {
        GR_TRAP  = 2'd0,
        GR_FLUSH = 2'd1,
        GR_FULL  = 2'd2
    } grant_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_EXEC_FLUSH,
        ST_ILLEGAL,
        ST_VIRTUAL
    } verdict_e;

endpackage

// File: rtl/cbo_level_gate.sv
module cbo_level_gate
    import cbo_perm_pkg::*;
(
    input  logic [OP_W-1:0]  op_i,
    input  logic [CFG_W-1:0] cfg_i,
    output grant_e           grant_o
);

    logic [1:0] inval_fld;
    assign inval_fld = cfg_i[1:0];

    always_comb begin
        grant_o = GR_TRAP;
        case (op_i)
            OPC_INVAL: begin
                case (inval_fld)
                    2'b01:   grant_o = GR_FLUSH;
                    2'b11:   grant_o = GR_FULL;
                    default: grant_o = GR_TRAP;   // 00 and reserved 10
                endcase
            end
            OPC_CLEAN,
            OPC_FLUSH: grant_o = cfg_i[2] ? GR_FULL : GR_TRAP;
            OPC_ZERO:  grant_o = cfg_i[3] ? GR_FULL : GR_TRAP;
            OPC_PREF:  grant_o = GR_FULL;
            default:   grant_o = GR_TRAP;
        endcase
    end

endmodule

// File: rtl/cbo_verdict_logic.sv
module cbo_verdict_logic
    import cbo_perm_pkg::*;
(
    input  logic              valid_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [OP_W-1:0]   op_i,
    input  grant_e            gr_m_i,
    input  grant_e            gr_s_i,
    input  grant_e            gr_h_i,
    output verdict_e          next_o
);

    logic mode_ok, op_ok;
    logic use_m, use_s_ill, use_h_virt, use_s_virt;
    logic ill, virt, demote;

    always_comb begin
        mode_ok    = 1'b1;
        use_m      = 1'b0;
        use_s_ill  = 1'b0;
        use_h_virt = 1'b0;
        use_s_virt = 1'b0;
        case (mode_i)
            MD_M:  ;
            MD_S:  use_m = 1'b1;
            MD_U:  begin use_m = 1'b1; use_s_ill = 1'b1; end
            MD_VS: begin use_m = 1'b1; use_h_virt = 1'b1; end
            MD_VU: begin use_m = 1'b1; use_h_virt = 1'b1; use_s_virt = 1'b1; end
            default: mode_ok = 1'b0;
        endcase
        op_ok = (op_i <= OPC_PREF);

        ill = !mode_ok || !op_ok
            || (use_m     && (gr_m_i == GR_TRAP))
            || (use_s_ill && (gr_s_i == GR_TRAP));

        virt = !ill
            && ((use_h_virt && (gr_h_i == GR_TRAP))
             || (use_s_virt && (gr_s_i == GR_TRAP)));

        demote = (use_m && (gr_m_i == GR_FLUSH))
              || ((use_s_ill || use_s_virt) && (gr_s_i == GR_FLUSH))
              || (use_h_virt && (gr_h_i == GR_FLUSH));

        if (!valid_i)   next_o = ST_IDLE;
        else if (ill)   next_o = ST_ILLEGAL;
        else if (virt)  next_o = ST_VIRTUAL;
        else if (demote) next_o = ST_EXEC_FLUSH;
        else            next_o = ST_EXEC;
    end

endmodule

// File: rtl/cbo_perm_checker.sv
module cbo_perm_checker
    import cbo_perm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [CFG_W-1:0]  m_cfg_i,
    input  logic [CFG_W-1:0]  s_cfg_i,
    input  logic [CFG_W-1:0]  h_cfg_i,
    output logic              exec_o,
    output logic              as_flush_o,
    output logic              illegal_o,
    output logic              virtual_o
);

    logic [CFG_W-1:0] cfg_arr [N_LVL];
    grant_e           grant   [N_LVL];
    verdict_e         state_q, state_d;

    assign cfg_arr[LVL_M] = m_cfg_i;
    assign cfg_arr[LVL_S] = s_cfg_i;
    assign cfg_arr[LVL_H] = h_cfg_i;

    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        cbo_level_gate u_gate (
            .op_i    (op_i),
            .cfg_i   (cfg_arr[g]),
            .grant_o (grant[g])
        );
    end

    cbo_verdict_logic u_verdict (
        .valid_i (valid_i),
        .mode_i  (mode_i),
        .op_i    (op_i),
        .gr_m_i  (grant[LVL_M]),
        .gr_s_i  (grant[LVL_S]),
        .gr_h_i  (grant[LVL_H]),
        .next_o  (state_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        exec_o     = 1'b0;
        as_flush_o = 1'b0;
        illegal_o  = 1'b0;
        virtual_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:       ;
            ST_EXEC:       exec_o = 1'b1;
            ST_EXEC_FLUSH: begin exec_o = 1'b1; as_flush_o = 1'b1; end
            ST_ILLEGAL:    illegal_o = 1'b1;
            ST_VIRTUAL:    virtual_o = 1'b1;
            default:       ;
        endcase
    end

endmodule

// File: rtl/cbo_perm_sva.sv
module cbo_perm_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       valid_i,
    input logic [2:0] mode_i,
    input logic [2:0] op_i,
    input logic       exec_o,
    input logic       as_flush_o,
    input logic       illegal_o,
    input logic       virtual_o
);

    logic       v_q;
    logic [2:0] mode_q, op_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            mode_q <= 3'b000;
            op_q   <= 3'd0;
        end else begin
            v_q    <= valid_i;
            mode_q <= mode_i;
            op_q   <= op_i;
        end
    end

    // R2: no request, no output
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !v_q |-> !(exec_o || as_flush_o || illegal_o || virtual_o));

    // R8: exactly one verdict per valid request
    p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> ($countones({exec_o, illegal_o, virtual_o}) == 1));

    // R7: prefetch in a listed mode always runs
    p_prefetch_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && op_q == 3'd4 && (mode_q inside {3'b000, 3'b001, 3'b011, 3'b100, 3'b101}))
        |-> exec_o);

    // R9: demotion only with execution of an invalidate
    p_flush_with_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        as_flush_o |-> (exec_o && op_q == 3'd0 && mode_q != 3'b011));

    // R5: machine mode never traps a listed operation
    p_mmode_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && mode_q == 3'b011 && op_q <= 3'd4) |-> exec_o);

    // R6: virtual exception only from virtualized modes
    p_virt_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        virtual_o |-> (mode_q == 3'b100 || mode_q == 3'b101));

endmodule

bind cbo_perm_checker cbo_perm_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .mode_i     (mode_i),
    .op_i       (op_i),
    .exec_o     (exec_o),
    .as_flush_o (as_flush_o),
    .illegal_o  (illegal_o),
    .virtual_o  (virtual_o)
);

// File: tb/cbo_perm_checker_tb.sv
module cbo_perm_checker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [2:0] mode_i = 3'b000;
    logic [2:0] op_i = 3'd0;
    logic [3:0] m_cfg_i = 4'd0, s_cfg_i = 4'd0, h_cfg_i = 4'd0;
    logic       exec_o, as_flush_o, illegal_o, virtual_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cbo_perm_checker dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i), .op_i(op_i),
        .m_cfg_i(m_cfg_i), .s_cfg_i(s_cfg_i), .h_cfg_i(h_cfg_i),
        .exec_o(exec_o), .as_flush_o(as_flush_o), .illegal_o(illegal_o), .virtual_o(virtual_o)
    );

    function automatic bit allowed(input logic [2:0] op, input logic [3:0] c);
        case (op)
            3'd0:       return c[0];          // 01 or 11
            3'd1, 3'd2: return c[2];
            3'd3:       return c[3];
            3'd4:       return 1'b1;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic bit flushy(input logic [2:0] op, input logic [3:0] c);
        return (op == 3'd0) && (c[1:0] == 2'b01);
    endfunction

    // returns {exec, flush, illegal, virtual}
    function automatic logic [3:0] expect_of(input logic v, input logic [2:0] md,
        input logic [2:0] op, input logic [3:0] m, input logic [3:0] s, input logic [3:0] h);
        bit ill, virt, fl;
        if (!v) return 4'b0000;
        if (!(md inside {3'b000, 3'b001, 3'b011, 3'b100, 3'b101}) || op > 3'd4) return 4'b0010;
        if (op == 3'd4) return 4'b1000;
        ill  = (md != 3'b011 && !allowed(op, m)) || (md == 3'b000 && !allowed(op, s));
        virt = !ill && ((md == 3'b101 && !allowed(op, h)) ||
                        (md == 3'b100 && (!allowed(op, h) || !allowed(op, s))));
        if (ill)  return 4'b0010;
        if (virt) return 4'b0001;
        fl = (md != 3'b011 && flushy(op, m)) ||
             ((md == 3'b000 || md == 3'b100) && flushy(op, s)) ||
             ((md == 3'b101 || md == 3'b100) && flushy(op, h));
        return {1'b1, fl, 2'b00};
    endfunction

    function automatic string tag_of(input logic v, input logic [2:0] md, input logic [2:0] op,
        input logic [3:0] m, input logic [3:0] s, input logic [3:0] h, input logic [3:0] e);
        if (!v) return "R2";
        if (!(md inside {3'b000, 3'b001, 3'b011, 3'b100, 3'b101}) || op > 3'd4) return "R10";
        if (op == 3'd4) return "R7";
        if (op == 3'd0 && (m[1:0] == 2'b10 || s[1:0] == 2'b10 || h[1:0] == 2'b10)) return "R3";
        if (e[1]) return "R5";
        if (e[0]) return "R6";
        if (e[2]) return "R9";
        if (op == 3'd0) return "R3";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: mode=%b op=%0d m=%h s=%h h=%h actual=%b expected=%b",
                     tag, mode_i, op_i, m_cfg_i, s_cfg_i, h_cfg_i, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [2:0] md, input logic [2:0] op,
                         input logic [11:0] cfg);
        logic [3:0] e;
        logic [3:0] act;
        @(negedge clk);
        valid_i = v; mode_i = md; op_i = op;
        m_cfg_i = cfg[3:0]; s_cfg_i = cfg[7:4]; h_cfg_i = cfg[11:8];
        @(posedge clk);
        #1;
        e   = expect_of(v, md, op, cfg[3:0], cfg[7:4], cfg[11:8]);
        act = {exec_o, as_flush_o, illegal_o, virtual_o};
        check(tag_of(v, md, op, cfg[3:0], cfg[7:4], cfg[11:8], e), act, e);
        if (v) check("R8", {3'b000, $countones({act[3], act[1], act[0]}) == 1}, 4'b0001);
    endtask

    initial begin : wd
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [2:0] modes [5];
        modes = '{3'b000, 3'b001, 3'b011, 3'b100, 3'b101};
        // R1: outputs quiet in reset even with a request present
        valid_i = 1'b1; op_i = 3'd4; mode_i = 3'b011;
        repeat (3) @(posedge clk);
        #1;
        check("R1", {exec_o, as_flush_o, illegal_o, virtual_o}, 4'b0000);
        @(negedge clk);
        valid_i = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", {exec_o, as_flush_o, illegal_o, virtual_o}, 4'b0000);

        // R2: invalid cycles with hostile inputs
        for (int i = 0; i < 8; i++) apply(1'b0, 3'(i), 3'(i), 12'h000);
        // main sweep over listed modes and ops (R3 R4 R5 R6 R7 R9)
        for (int mi = 0; mi < 5; mi++)
            for (int op = 0; op < 5; op++)
                for (int c = 0; c < 4096; c++)
                    apply(1'b1, modes[mi], 3'(op), 12'(c));
        // R10: unlisted modes and ops
        for (int md = 0; md < 8; md++)
            for (int op = 0; op < 8; op++)
                for (int c = 0; c < 4096; c += 273)
                    if (!(md inside {0, 1, 3, 4, 5}) || op > 4)
                        apply(1'b1, 3'(md), 3'(op), 12'(c));
        // R2: valid drop after a trap
        apply(1'b1, 3'b000, 3'd3, 12'h000);
        apply(1'b0, 3'b000, 3'd3, 12'h000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule